// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the part of an in-order processor's control path that takes over at an instruction boundary when a trap or an external interrupt is waiting, or when a return-from-handler instruction has just completed. On entry it saves the program counter and the status word on the kernel stack, reads a handler address from a vector table, and loads that address into the program counter with interrupts masked. On return it pulls the status word and the program counter back off the kernel stack and resumes at the restored address.

Traps and external interrupts go through the same path and share one vector table. Software sets the table's location through a base register. The saved state always goes to the kernel stack pointer, never to the stack pointer of the code that was running. The processor's architectural registers live outside the block. The block reads them as inputs and updates them through write-enable and value pairs, all in one commit cycle. Memory is reached through one request/acknowledge port that can take any number of wait cycles.

Top module: `irq_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `mem_req`, `take_irq`, `take_trap` and all three register write enables are 0.
- R2: A request is acted on only in a cycle where `insn_done` is 1 and the block is idle. Requests held without `insn_done`, or presented while a sequence is running, start nothing.
- R3: An external interrupt is taken only when the interrupt-enable bit (bit 0 of the status word) is 1. A trap is taken whatever that bit holds.
- R4: At one boundary a trap wins over a return, and a return wins over an external interrupt. `take_trap` or `take_irq` is 1 for exactly the one cycle after the boundary in which that kind of request is accepted. The two are never 1 together.
- R5: Entry writes the program counter to kernel-stack-pointer minus 4, then writes the zero-extended status word to kernel-stack-pointer minus 8.
- R6: After the two writes, entry reads the word at table base plus 4 times the vector number. This holds up to vector 255. The word it reads becomes the new program counter.
- R7: Entry ends with one commit cycle in which `pc_wr_en`, `sr_wr_en` and `ksp_wr_en` are all 1. The new values are the fetched handler address, the saved status with bit 0 cleared, and the kernel stack pointer minus 8. The block is idle in the next cycle.
- R8: A return reads the status word at the kernel stack pointer, then the program counter at the kernel stack pointer plus 4. It then commits those two values and the kernel stack pointer plus 8 in one cycle.
- R9: While `mem_req` is 1 and `mem_ack` is 0, the request, its address, its write data and its direction do not change. Each access ends in the cycle `mem_ack` is 1, whatever the number of wait cycles.
- R10: Nested entries stack correctly. Each return restores the state saved by the most recent entry that has not yet been returned from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | Current instruction has fully completed (boundary) |
| trap_req | input | 1 | Trap pending |
| trap_num | input | VEC_W | Trap vector number |
| irq_req | input | 1 | External interrupt pending |
| irq_num | input | VEC_W | External interrupt vector number |
| ret_req | input | 1 | Completed instruction was a return-from-handler |
| pc_i | input | XLEN | Program counter of the next instruction |
| sr_i | input | SR_W | Current status word |
| ksp_i | input | XLEN | Kernel stack pointer |
| tbase_i | input | XLEN | Vector table base address |
| pc_wr_en | output | 1 | Load program counter |
| pc_wr_val | output | XLEN | New program counter |
| sr_wr_en | output | 1 | Load status word |
| sr_wr_val | output | SR_W | New status word |
| ksp_wr_en | output | 1 | Load kernel stack pointer |
| ksp_wr_val | output | XLEN | New kernel stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | XLEN | Access address |
| mem_wdata | output | XLEN | Write data |
| mem_rdata | input | XLEN | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| busy | output | 1 | Sequence in progress (processor stalls) |
| take_irq | output | 1 | External interrupt accepted (acknowledge) |
| take_trap | output | 1 | Trap accepted |

## Verification
The accept pulse and `busy` show up one cycle after the boundary edge. The first memory request appears in that same cycle. Each later access starts in the cycle after the previous one is acknowledged, and the commit comes one cycle after the last read is acknowledged. The bench samples the accept pulse and `busy` on the falling edge right after the boundary. A scoreboard checks every acknowledged access and the commit in the order they occur, so the exact cycle of each result follows the memory model's wait count, which the bench varies from 0 to 3 cycles. Ignored requests are checked by watching `busy`, the accept pulses and the program counter, and by confirming that no unexpected memory access reaches the scoreboard.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_SR,
        ST_VEC_RD,
        ST_POP_SR,
        ST_POP_PC,
        ST_COMMIT
    } seq_state_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_TRAP,
        ACT_RET,
        ACT_IRQ
    } seq_act_e;

endpackage

// File: rtl/irq_seq_arb.sv
module irq_seq_arb
    import irq_seq_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int SR_W   = 16,
    parameter int IE_BIT = 0
) (
    input  logic             idle,
    input  logic             insn_done,
    input  logic             trap_req,
    input  logic [VEC_W-1:0] trap_num,
    input  logic             irq_req,
    input  logic [VEC_W-1:0] irq_num,
    input  logic             ret_req,
    input  logic [SR_W-1:0]  sr_i,
    output seq_act_e         act,
    output logic [VEC_W-1:0] vec
);

    logic boundary;
    assign boundary = idle && insn_done;

    always_comb begin
        act = ACT_NONE;
        vec = '0;
        if (boundary) begin
            if (trap_req) begin
                act = ACT_TRAP;
                vec = trap_num;
            end else if (ret_req) begin
                act = ACT_RET;
            end else if (irq_req && sr_i[IE_BIT]) begin
                act = ACT_IRQ;
                vec = irq_num;
            end
        end
    end

endmodule

// File: rtl/irq_seq_agen.sv
module irq_seq_agen
    import irq_seq_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int VEC_W = 8
) (
    input  seq_state_e       st,
    input  logic [XLEN-1:0]  ksp,
    input  logic [XLEN-1:0]  tbase,
    input  logic [VEC_W-1:0] vec,
    output logic [XLEN-1:0]  addr
);

    localparam int          WORD_B = XLEN / 8;
    localparam int          SHIFT  = $clog2(WORD_B);
    localparam logic [XLEN-1:0] STEP = XLEN'(WORD_B);

    logic [XLEN-1:0] vec_off;
    assign vec_off = XLEN'(vec) << SHIFT;

    always_comb begin
        unique case (st)
            ST_PUSH_PC: addr = ksp - STEP;
            ST_PUSH_SR: addr = ksp - (STEP << 1);
            ST_VEC_RD:  addr = tbase + vec_off;
            ST_POP_SR:  addr = ksp;
            ST_POP_PC:  addr = ksp + STEP;
            default:    addr = ksp;
        endcase
    end

endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_seq_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int SR_W   = 16,
    parameter int VEC_W  = 8,
    parameter int IE_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             insn_done,
    input  logic             trap_req,
    input  logic [VEC_W-1:0] trap_num,
    input  logic             irq_req,
    input  logic [VEC_W-1:0] irq_num,
    input  logic             ret_req,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [SR_W-1:0]  sr_i,
    input  logic [XLEN-1:0]  ksp_i,
    input  logic [XLEN-1:0]  tbase_i,
    output logic             pc_wr_en,
    output logic [XLEN-1:0]  pc_wr_val,
    output logic             sr_wr_en,
    output logic [SR_W-1:0]  sr_wr_val,
    output logic             ksp_wr_en,
    output logic [XLEN-1:0]  ksp_wr_val,
    output logic             mem_req,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic [XLEN-1:0]  mem_rdata,
    input  logic             mem_ack,
    output logic             busy,
    output logic             take_irq,
    output logic             take_trap
);

    localparam logic [XLEN-1:0] FRAME   = XLEN'(2 * (XLEN / 8));
    localparam logic [SR_W-1:0] IE_MASK = SR_W'(1) << IE_BIT;

    typedef struct packed {
        seq_state_e       st;
        logic             is_ret;
        logic [VEC_W-1:0] vec;
        logic [XLEN-1:0]  spc;
        logic [SR_W-1:0]  ssr;
        logic [XLEN-1:0]  ksp;
        logic [XLEN-1:0]  tbase;
        logic [XLEN-1:0]  npc;
        logic [SR_W-1:0]  nsr;
        logic             tk_irq;
        logic             tk_trap;
    } seq_t;

    seq_t     r_q, r_d;
    seq_act_e act;
    logic [VEC_W-1:0] arb_vec;
    logic             idle;

    assign idle = (r_q.st == ST_IDLE);

    irq_seq_arb #(
        .VEC_W  (VEC_W),
        .SR_W   (SR_W),
        .IE_BIT (IE_BIT)
    ) u_arb (
        .idle      (idle),
        .insn_done (insn_done),
        .trap_req  (trap_req),
        .trap_num  (trap_num),
        .irq_req   (irq_req),
        .irq_num   (irq_num),
        .ret_req   (ret_req),
        .sr_i      (sr_i),
        .act       (act),
        .vec       (arb_vec)
    );

    irq_seq_agen #(
        .XLEN  (XLEN),
        .VEC_W (VEC_W)
    ) u_agen (
        .st    (r_q.st),
        .ksp   (r_q.ksp),
        .tbase (r_q.tbase),
        .vec   (r_q.vec),
        .addr  (mem_addr)
    );

    always_comb begin
        r_d         = r_q;
        r_d.tk_irq  = 1'b0;
        r_d.tk_trap = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (act != ACT_NONE) begin
                    r_d.spc     = pc_i;
                    r_d.ssr     = sr_i;
                    r_d.ksp     = ksp_i;
                    r_d.tbase   = tbase_i;
                    r_d.vec     = arb_vec;
                    r_d.is_ret  = (act == ACT_RET);
                    r_d.tk_irq  = (act == ACT_IRQ);
                    r_d.tk_trap = (act == ACT_TRAP);
                    r_d.st      = (act == ACT_RET) ? ST_POP_SR : ST_PUSH_PC;
                end
            end
            ST_PUSH_PC: begin
                if (mem_ack) r_d.st = ST_PUSH_SR;
            end
            ST_PUSH_SR: begin
                if (mem_ack) r_d.st = ST_VEC_RD;
            end
            ST_VEC_RD: begin
                if (mem_ack) begin
                    r_d.npc = mem_rdata;
                    r_d.nsr = r_q.ssr & ~IE_MASK;
                    r_d.st  = ST_COMMIT;
                end
            end
            ST_POP_SR: begin
                if (mem_ack) begin
                    r_d.nsr = mem_rdata[SR_W-1:0];
                    r_d.st  = ST_POP_PC;
                end
            end
            ST_POP_PC: begin
                if (mem_ack) begin
                    r_d.npc = mem_rdata;
                    r_d.st  = ST_COMMIT;
                end
            end
            ST_COMMIT: r_d.st = ST_IDLE;
            default:   r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.st      <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = !idle;
    assign take_irq  = r_q.tk_irq;
    assign take_trap = r_q.tk_trap;

    assign mem_req   = (r_q.st == ST_PUSH_PC) || (r_q.st == ST_PUSH_SR) ||
                       (r_q.st == ST_VEC_RD)  || (r_q.st == ST_POP_SR)  ||
                       (r_q.st == ST_POP_PC);
    assign mem_we    = (r_q.st == ST_PUSH_PC) || (r_q.st == ST_PUSH_SR);
    assign mem_wdata = (r_q.st == ST_PUSH_PC) ? r_q.spc : XLEN'(r_q.ssr);

    assign pc_wr_en   = (r_q.st == ST_COMMIT);
    assign sr_wr_en   = (r_q.st == ST_COMMIT);
    assign ksp_wr_en  = (r_q.st == ST_COMMIT);
    assign pc_wr_val  = r_q.npc;
    assign sr_wr_val  = r_q.nsr;
    assign ksp_wr_val = r_q.is_ret ? (r_q.ksp + FRAME) : (r_q.ksp - FRAME);

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    // R4
    take_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_irq, take_trap}));

    // R2
    no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !insn_done) |=> !busy);

    // R3
    ie_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && insn_done && !trap_req && !ret_req && !sr_i[IE_BIT]) |=> !busy);

    // R7
    commit_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_en |=> !busy);

endmodule

// File: tb/irq_seq_tb.sv
module irq_seq_tb;

    localparam int XLEN = 32;
    localparam int SR_W = 16;
    localparam int VEC_W = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst_n;
    logic             insn_done, trap_req, irq_req, ret_req;
    logic [VEC_W-1:0] trap_num, irq_num;
    logic [XLEN-1:0]  b_pc, b_ksp, b_tb;
    logic [SR_W-1:0]  b_sr;
    logic             pc_wr_en, sr_wr_en, ksp_wr_en;
    logic [XLEN-1:0]  pc_wr_val, ksp_wr_val;
    logic [SR_W-1:0]  sr_wr_val;
    logic             mem_req, mem_we, mem_ack;
    logic [XLEN-1:0]  mem_addr, mem_wdata, mem_rdata;
    logic             busy, take_irq, take_trap;

    irq_seq u_dut (
        .clk(clk), .rst_n(rst_n), .insn_done(insn_done),
        .trap_req(trap_req), .trap_num(trap_num),
        .irq_req(irq_req), .irq_num(irq_num), .ret_req(ret_req),
        .pc_i(b_pc), .sr_i(b_sr), .ksp_i(b_ksp), .tbase_i(b_tb),
        .pc_wr_en(pc_wr_en), .pc_wr_val(pc_wr_val),
        .sr_wr_en(sr_wr_en), .sr_wr_val(sr_wr_val),
        .ksp_wr_en(ksp_wr_en), .ksp_wr_val(ksp_wr_val),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .busy(busy), .take_irq(take_irq), .take_trap(take_trap)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] handler(input int v);
        return 32'h0010_0000 + 32'(v) * 32'h10;
    endfunction

    // ---------------- memory model with variable wait ----------------
    logic [31:0] mem [logic [31:0]];
    int lat = 0;
    int wcnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            wcnt      <= 0;
        end else if (mem_req && !mem_ack) begin
            if (wcnt >= lat) begin
                mem_ack <= 1'b1;
                wcnt    <= 0;
                if (mem_we) mem[mem_addr] = mem_wdata;
                mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // ---------------- processor registers ----------------
    logic             ld;
    logic [XLEN-1:0]  ld_pc, ld_ksp, ld_tb;
    logic [SR_W-1:0]  ld_sr;

    always @(posedge clk) begin
        if (ld) begin
            b_pc <= ld_pc; b_sr <= ld_sr; b_ksp <= ld_ksp; b_tb <= ld_tb;
        end else begin
            if (pc_wr_en)  b_pc  <= pc_wr_val;
            if (sr_wr_en)  b_sr  <= sr_wr_val;
            if (ksp_wr_en) b_ksp <= ksp_wr_val;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        int          kind;   // 0 write, 1 read, 2 commit
        logic [31:0] addr;
        logic [31:0] data;
        logic [15:0] sr;
        logic [31:0] ksp;
        string       tag;
    } item_t;

    item_t q[$];
    logic [47:0] shadow[$];

    always @(negedge clk) begin
        item_t it;
        if (rst_n) begin
            if (mem_req && mem_ack) begin
                if (q.size() == 0) begin
                    chk(0, "R2 unexpected memory access", mem_addr, 32'h0);
                end else begin
                    it = q.pop_front();
                    chk(it.kind == (mem_we ? 0 : 1), {it.tag, " access direction"},
                        32'(mem_we), 32'(it.kind == 0));
                    chk(mem_addr == it.addr, {it.tag, " address"}, mem_addr, it.addr);
                    if (it.kind == 0)
                        chk(mem_wdata == it.data, {it.tag, " write data"}, mem_wdata, it.data);
                end
            end
            if (pc_wr_en) begin
                if (q.size() == 0) begin
                    chk(0, "R2 unexpected commit", pc_wr_val, 32'h0);
                end else begin
                    it = q.pop_front();
                    chk(it.kind == 2, {it.tag, " commit order"}, 32'(it.kind), 32'd2);
                    chk(pc_wr_val == it.data, {it.tag, " new pc"}, pc_wr_val, it.data);
                    chk(sr_wr_en && sr_wr_val == it.sr, {it.tag, " new status"},
                        32'(sr_wr_val), 32'(it.sr));
                    chk(ksp_wr_en && ksp_wr_val == it.ksp, {it.tag, " new kernel sp"},
                        ksp_wr_val, it.ksp);
                end
            end
        end
    end

    task automatic push(input int k, input logic [31:0] a, input logic [31:0] d,
                        input logic [15:0] s, input logic [31:0] sp, input string tag);
        item_t it;
        it.kind = k; it.addr = a; it.data = d; it.sr = s; it.ksp = sp; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic set_regs(input logic [31:0] pc, input logic [15:0] sr,
                            input logic [31:0] sp, input logic [31:0] tb);
        @(negedge clk);
        ld = 1'b1; ld_pc = pc; ld_sr = sr; ld_ksp = sp; ld_tb = tb;
        @(negedge clk);
        ld = 1'b0;
    endtask

    // driver: present one boundary, predict and queue the results
    task automatic boundary(input bit t, input int tn, input bit i, input int inn,
                            input bit r, input bit poke, input string tag);
        int act;     // 0 none, 1 trap, 2 return, 3 irq
        int v;
        int n;
        logic [31:0] exp_pc;
        logic [47:0] top;
        @(negedge clk);
        act = t ? 1 : (r ? 2 : ((i && b_sr[0]) ? 3 : 0));
        v = t ? tn : inn;
        exp_pc = b_pc;
        if (act == 1 || act == 3) begin
            push(0, b_ksp - 4, b_pc, '0, '0, {tag, " R5 push pc"});
            push(0, b_ksp - 8, 32'(b_sr), '0, '0, {tag, " R5 push status"});
            push(1, b_tb + 32'(v) * 4, '0, '0, '0, {tag, " R6 vector read"});
            push(2, '0, handler(v), b_sr & 16'hFFFE, b_ksp - 8, {tag, " R7 entry commit"});
            shadow.push_back({b_pc, b_sr});
            exp_pc = handler(v);
        end else if (act == 2) begin
            top = shadow.pop_back();
            push(1, b_ksp, '0, '0, '0, {tag, " R8 pop status"});
            push(1, b_ksp + 4, '0, '0, '0, {tag, " R8 pop pc"});
            push(2, '0, top[47:16], top[15:0], b_ksp + 8, {tag, " R8 return commit"});
            exp_pc = top[47:16];
        end
        trap_req = t; trap_num = VEC_W'(tn);
        irq_req = i;  irq_num = VEC_W'(inn);
        ret_req = r;  insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0; trap_req = 1'b0; irq_req = 1'b0; ret_req = 1'b0;
        chk(take_trap == (act == 1), {tag, " R4 take_trap pulse"}, 32'(take_trap), 32'(act == 1));
        chk(take_irq == (act == 3), {tag, " R4 take_irq pulse"}, 32'(take_irq), 32'(act == 3));
        chk(busy == (act != 0), {tag, " R2 busy after boundary"}, 32'(busy), 32'(act != 0));
        if (poke) begin
            // R2: a second boundary while busy must start nothing
            trap_req = 1'b1; irq_req = 1'b1; insn_done = 1'b1;
            @(negedge clk);
            trap_req = 1'b0; irq_req = 1'b0; insn_done = 1'b0;
        end
        @(negedge clk);
        chk(take_trap == 1'b0 && take_irq == 1'b0, {tag, " R4 pulse is one cycle"},
            32'({take_trap, take_irq}), 32'h0);
        n = 0;
        while (busy && n < 200) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        chk(!busy && q.size() == 0, {tag, " R7 sequence complete and idle"},
            32'(q.size()), 32'h0);
        chk(b_pc == exp_pc, {tag, " resulting pc"}, b_pc, exp_pc);
    endtask

    initial begin
        #3000000;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; insn_done = 1'b0; trap_req = 1'b0; irq_req = 1'b0;
        ret_req = 1'b0; trap_num = '0; irq_num = '0; ld = 1'b0;
        ld_pc = '0; ld_sr = '0; ld_ksp = '0; ld_tb = '0;
        for (int v = 0; v < 256; v++) mem[32'h8000 + 32'(v) * 4] = handler(v);
        repeat (4) @(negedge clk);
        // R1: idle state while and right after reset
        chk(!busy && !mem_req && !pc_wr_en && !sr_wr_en && !ksp_wr_en,
            "R1 outputs idle in reset", 32'({busy, mem_req, pc_wr_en}), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !take_irq && !take_trap, "R1 idle after reset",
            32'({busy, take_irq, take_trap}), 32'h0);
        chk(!mem_req, "R1 no memory request after reset", 32'(mem_req), 32'h0);

        set_regs(32'h400, 16'h0001, 32'h9000, 32'h8000);
        lat = 0;
        boundary(0, 0, 1, 5, 0, 0, "irq5 R3");
        chk(b_ksp == 32'h8FF8 && b_sr == 16'h0000, "R7 registers after entry",
            b_ksp, 32'h8FF8);
        boundary(0, 0, 0, 0, 1, 0, "ret R8");
        chk(b_ksp == 32'h9000 && b_sr == 16'h0001, "R8 registers after return",
            b_ksp, 32'h9000);

        // R3: interrupt blocked when enable bit is clear
        set_regs(32'h404, 16'h0002, 32'h9000, 32'h8000);
        boundary(0, 0, 1, 7, 0, 0, "irq masked R3");

        // R2: request held without a boundary
        set_regs(32'h408, 16'h0001, 32'h9000, 32'h8000);
        @(negedge clk);
        irq_req = 1'b1; irq_num = 8'd6;
        repeat (6) @(negedge clk);
        chk(!busy && !take_irq && b_pc == 32'h408, "R2 request without boundary ignored",
            b_pc, 32'h408);
        irq_req = 1'b0;

        // R4 trap over irq, R9 with wait cycles
        lat = 2;
        set_regs(32'h520, 16'h0001, 32'h9000, 32'h8000);
        boundary(1, 9, 1, 4, 0, 0, "trap9 over irq R4 R9");
        // nested: irq now masked, trap still taken; poke during busy
        boundary(0, 0, 1, 4, 0, 0, "irq in handler R3");
        lat = 1;
        boundary(1, 3, 0, 0, 0, 1, "nested trap3 R10");
        chk(b_ksp == 32'h8FF0, "R10 kernel sp after nesting", b_ksp, 32'h8FF0);
        lat = 3;
        boundary(0, 0, 0, 0, 1, 0, "inner ret R10");
        boundary(0, 0, 0, 0, 1, 0, "outer ret R10");
        chk(b_ksp == 32'h9000 && b_sr == 16'h0001 && b_pc == 32'h520,
            "R10 state after unwinding", b_pc, 32'h520);

        // R6 highest vector, then R4 return over irq
        lat = 0;
        boundary(0, 0, 1, 255, 0, 0, "irq255 R6");
        set_regs(b_pc, 16'h0001, b_ksp, b_tb);
        boundary(0, 0, 1, 2, 1, 0, "ret over irq R4");
        // R4 trap over return
        boundary(1, 1, 0, 0, 1, 0, "trap over ret R4");
        boundary(0, 0, 0, 0, 1, 0, "ret after trap R8");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule